// File: doc/BRIEF.md
# Pipelined Adder with Drain and Reload

This block is a fixed-depth adder pipeline that has two ways to issue work. In pipelined mode the pipeline moves forward only when an operation is issued. Each issue pushes a new operand pair, with its sum, into the first stage. It also returns the result that was sitting in the last stage, which belongs to the pipelined operation issued a full depth earlier. In scalar mode an operation goes through a separate chain that always advances, and its own sum comes back a fixed number of cycles later. Scalar work leaves the pipelined contents alone.

There is no dedicated save or restore port. Software empties the pipeline by issuing a depth's worth of additions of zero and keeping what comes back. To put the state back, it issues the saved values, oldest first, each added to zero. Every stage carries an exception flag next to its data. The flag marks signed overflow of the 32-bit stand-in add. A reload input can force the flag on the entering operation, so a saved exception state goes back in along with its value.

Top module: `padd_pipe_top`

## Requirements
- R1: A pipelined issue (`issue_vld`=1 with `pipe_mode`=1) drives `res_vld` high for exactly the one cycle after the clock edge that samples it. `res_vld` is low in every other cycle.
- R2: The value returned on `res_data`/`res_exc` is the sum and flag of the pipelined operation issued DEPTH pipelined issues earlier. The first DEPTH pipelined issues after reset return 0 with the flag clear.
- R3: In a cycle with no pipelined issue, the pipeline contents do not change, `res_vld` is low, and `res_data`/`res_exc` keep their last values.
- R4: Save: DEPTH pipelined issues with both operands zero return the in-flight results, oldest first, each with its own flag.
- R5: Restore: issuing the saved values oldest first, each added to zero with `exc_load` equal to the saved flag, rebuilds the earlier in-flight contents exactly.
- R6: An operation's flag is set when the signed two's-complement add of its operands overflows. The flag comes out together with that operation's sum.
- R7: `exc_load`=1 on an issue forces the flag of the entering operation to 1, whether or not the add overflows.
- R8: A scalar issue (`issue_vld`=1 with `pipe_mode`=0) makes `sc_vld` high, carrying its own sum and flag on `sc_data`/`sc_exc`, in the cycle after the DEPTH-th rising edge counted from the sampling edge. Scalar issues may be made back to back.
- R9: A scalar issue does not drive `res_vld` and leaves the pipelined contents untouched.
- R10: A synchronous active-high reset clears every stage and the result registers to zero with their flags cleared, and clears both valid outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | Issue an operation this cycle |
| pipe_mode | input | 1 | 1 = pipelined issue, 0 = scalar issue |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand |
| exc_load | input | 1 | Force the exception flag of the entering operation |
| res_vld | output | 1 | Pipelined result returned this cycle |
| res_data | output | DATA_W | Pipelined returned sum |
| res_exc | output | 1 | Pipelined returned exception flag |
| sc_vld | output | 1 | Scalar result valid |
| sc_data | output | DATA_W | Scalar sum |
| sc_exc | output | 1 | Scalar exception flag |

## Verification
The bench builds the block with its default parameters: a 32-bit data word and a depth of three. With 32 bits, the signed overflow edges at 0x7FFFFFFF and 0x80000000 are reachable from directed operands. A depth of three keeps a whole drain-and-refill cycle short enough to check value by value, including a restored exception flag. At that depth, the scalar return falls on the third edge after issue, so back-to-back scalar work can be run while the pipelined contents are held.

// File: rtl/padd_pkg.sv
package padd_pkg;

    typedef enum logic {
        MODE_SCALAR = 1'b0,
        MODE_PIPE   = 1'b1
    } issue_mode_e;

    localparam int DEF_DATA_W = 32;
    localparam int DEF_DEPTH  = 3;

endpackage

// File: rtl/padd_entry.sv
module padd_entry #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              force_exc,
    output logic [DATA_W-1:0] sum,
    output logic              exc
);
    localparam int MSB = DATA_W - 1;

    logic ovf;

    always_comb begin
        sum = a + b;
        // signed overflow: like-signed operands give a result of the other sign
        ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
        exc = ovf | force_exc;
    end
endmodule

// File: rtl/padd_chain.sv
module padd_chain #(
    parameter int PW    = 33,
    parameter int DEPTH = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] dout
);
    logic [PW-1:0] stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)      stg[i] <= '0;
                else if (adv) stg[i] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)      stg[i] <= '0;
                else if (adv) stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/padd_pipe_top.sv
module padd_pipe_top
    import padd_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int DEPTH  = DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_vld,
    input  logic              pipe_mode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              exc_load,
    output logic              res_vld,
    output logic [DATA_W-1:0] res_data,
    output logic              res_exc,
    output logic              sc_vld,
    output logic [DATA_W-1:0] sc_data,
    output logic              sc_exc
);
    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic              exc;
    } slot_t;

    typedef struct packed {
        logic  vld;
        slot_t body;
    } sc_slot_t;

    localparam int SLOT_W = $bits(slot_t);
    localparam int SC_W   = $bits(sc_slot_t);

    issue_mode_e mode;
    logic        pipe_adv;
    logic        sc_go;
    slot_t       entry;
    slot_t       pipe_tail;
    slot_t       res_q;
    sc_slot_t    sc_in;
    sc_slot_t    sc_tail;

    assign mode     = issue_mode_e'(pipe_mode);
    assign pipe_adv = issue_vld && (mode == MODE_PIPE);
    assign sc_go    = issue_vld && (mode == MODE_SCALAR);

    padd_entry #(.DATA_W(DATA_W)) u_entry (
        .a         (op_a),
        .b         (op_b),
        .force_exc (exc_load),
        .sum       (entry.val),
        .exc       (entry.exc)
    );

    // pipelined chain: moves only on a pipelined issue
    padd_chain #(.PW(SLOT_W), .DEPTH(DEPTH)) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .adv  (pipe_adv),
        .din  (entry),
        .dout (pipe_tail)
    );

    // scalar chain: always advances, carries its own valid bit
    assign sc_in = '{vld: sc_go, body: entry};

    padd_chain #(.PW(SC_W), .DEPTH(DEPTH)) u_scalar (
        .clk  (clk),
        .rst  (rst),
        .adv  (1'b1),
        .din  (sc_in),
        .dout (sc_tail)
    );

    // the slot leaving the last stage is captured as the returned value
    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld <= 1'b0;
            res_q   <= '0;
        end else begin
            res_vld <= pipe_adv;
            if (pipe_adv) res_q <= pipe_tail;
        end
    end

    assign res_data = res_q.val;
    assign res_exc  = res_q.exc;
    assign sc_vld   = sc_tail.vld;
    assign sc_data  = sc_tail.body.val;
    assign sc_exc   = sc_tail.body.exc;
endmodule

// File: rtl/padd_pipe_chk.sv
module padd_pipe_chk #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              issue_vld,
    input logic              pipe_mode,
    input logic              res_vld,
    input logic [DATA_W-1:0] res_data,
    input logic              res_exc,
    input logic              sc_vld
);
    // record of scalar issues, one bit per cycle of scalar latency
    logic [DEPTH-1:0] sc_hist;

    always_ff @(posedge clk) begin
        if (rst) sc_hist <= '0;
        else     sc_hist <= {sc_hist[DEPTH-2:0], issue_vld && !pipe_mode};
    end

    assert_issue_returns_R1: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && pipe_mode) |=> res_vld);

    assert_return_has_issue_R1: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> $past(issue_vld && pipe_mode));

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
        !(issue_vld && pipe_mode) |=> (!res_vld && $stable(res_data) && $stable(res_exc)));

    assert_scalar_latency_R8: assert property (@(posedge clk) disable iff (rst)
        sc_vld == sc_hist[DEPTH-1]);

    assert_scalar_no_return_R9: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && !pipe_mode) |=> !res_vld);
endmodule

bind padd_pipe_top padd_pipe_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .issue_vld (issue_vld),
    .pipe_mode (pipe_mode),
    .res_vld   (res_vld),
    .res_data  (res_data),
    .res_exc   (res_exc),
    .sc_vld    (sc_vld)
);

// File: tb/padd_pipe_top_tb_top.sv
module padd_pipe_top_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         issue_vld = 1'b0;
    logic         pipe_mode = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         exc_load = 1'b0;
    logic         res_vld;
    logic [W-1:0] res_data;
    logic         res_exc;
    logic         sc_vld;
    logic [W-1:0] sc_data;
    logic         sc_exc;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    padd_pipe_top #(.DATA_W(W), .DEPTH(3)) dut_i (
        .clk(clk), .rst(rst), .issue_vld(issue_vld), .pipe_mode(pipe_mode),
        .op_a(op_a), .op_b(op_b), .exc_load(exc_load),
        .res_vld(res_vld), .res_data(res_data), .res_exc(res_exc),
        .sc_vld(sc_vld), .sc_data(sc_data), .sc_exc(sc_exc)
    );

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         ld;
        logic [W-1:0] ev;
        logic         ee;
    } vec_t;

    // pipelined issues from reset; expected value is the op three issues back (R2, R6, R7)
    localparam vec_t VEC [9] = '{
        '{32'd1,         32'd2,         1'b0, 32'd0,         1'b0},
        '{32'd10,        32'd20,        1'b0, 32'd0,         1'b0},
        '{32'h7FFFFFFF,  32'd1,         1'b0, 32'd0,         1'b0},
        '{32'd100,       32'hFFFFFFFF,  1'b0, 32'd3,         1'b0},
        '{32'd5,         32'd0,         1'b1, 32'd30,        1'b0},
        '{32'h80000000,  32'hFFFFFFFF,  1'b0, 32'h80000000,  1'b1},
        '{32'd0,         32'd0,         1'b0, 32'd99,        1'b0},
        '{32'd0,         32'd0,         1'b0, 32'd5,         1'b1},
        '{32'd0,         32'd0,         1'b0, 32'h7FFFFFFF,  1'b1}
    };

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pipe_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic ld,
                           input logic [W-1:0] ev, input logic ee, input string tag);
        @(negedge clk);
        issue_vld = 1'b1; pipe_mode = 1'b1; op_a = a; op_b = b; exc_load = ld;
        @(posedge clk);
        @(negedge clk);
        issue_vld = 1'b0; exc_load = 1'b0;
        chk({tag, " res_vld"}, W'(res_vld), W'(1));
        chk({tag, " res_data"}, res_data, ev);
        chk({tag, " res_exc"}, W'(res_exc), W'(ee));
    endtask

    task automatic sc_op(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] ev, input logic ee);
        @(negedge clk);
        issue_vld = 1'b1; pipe_mode = 1'b0; op_a = a; op_b = b; exc_load = 1'b0;
        @(posedge clk);
        @(negedge clk);
        issue_vld = 1'b0; pipe_mode = 1'b1;
        chk("R8 sc_vld early edge1", W'(sc_vld), W'(0));
        chk("R9 res_vld on scalar", W'(res_vld), W'(0));
        @(posedge clk); @(negedge clk);
        chk("R8 sc_vld early edge2", W'(sc_vld), W'(0));
        @(posedge clk); @(negedge clk);
        chk("R8 sc_vld", W'(sc_vld), W'(1));
        chk("R8 sc_data", sc_data, ev);
        chk("R6 sc_exc", W'(sc_exc), W'(ee));
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset res_vld", W'(res_vld), W'(0));
        chk("R10 reset res_data", res_data, '0);
        chk("R10 reset sc_vld", W'(sc_vld), W'(0));

        // table walk: R2, R6, R7
        for (int i = 0; i < 9; i++)
            pipe_op(VEC[i].a, VEC[i].b, VEC[i].ld, VEC[i].ev, VEC[i].ee, "R2 table");

        // R3: idle cycles hold outputs
        repeat (4) @(negedge clk);
        chk("R3 idle res_vld", W'(res_vld), W'(0));
        chk("R3 idle res_data", res_data, 32'h7FFFFFFF);
        chk("R3 idle res_exc", W'(res_exc), W'(1));

        // fill, then save by draining with zeros (R4)
        pipe_op(32'd11, 32'd0, 1'b0, 32'd0, 1'b0, "R2 fill");
        pipe_op(32'd22, 32'd0, 1'b0, 32'd0, 1'b0, "R2 fill");
        pipe_op(32'd30, 32'd3, 1'b1, 32'd0, 1'b0, "R7 fill");
        repeat (3) @(negedge clk);
        pipe_op(32'd0, 32'd0, 1'b0, 32'd11, 1'b0, "R4 save");
        pipe_op(32'd0, 32'd0, 1'b0, 32'd22, 1'b0, "R4 save");
        pipe_op(32'd0, 32'd0, 1'b0, 32'd33, 1'b1, "R4 save");

        // restore saved values, oldest first (R5)
        pipe_op(32'd11, 32'd0, 1'b0, 32'd0, 1'b0, "R5 restore");
        pipe_op(32'd22, 32'd0, 1'b0, 32'd0, 1'b0, "R5 restore");
        pipe_op(32'd33, 32'd0, 1'b1, 32'd0, 1'b0, "R5 restore");

        // scalar work between (R8, R6, R9)
        sc_op(32'd40, 32'd2, 32'd42, 1'b0);
        sc_op(32'h7FFFFFFF, 32'h7FFFFFFF, 32'hFFFFFFFE, 1'b1);

        // back-to-back scalar issues (R8)
        @(negedge clk);
        issue_vld = 1'b1; pipe_mode = 1'b0; op_a = 32'd3; op_b = 32'd4;
        @(posedge clk); @(negedge clk);
        op_a = 32'hFFFFFFFB; op_b = 32'd1;
        @(posedge clk); @(negedge clk);
        issue_vld = 1'b0; pipe_mode = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R8 b2b first vld", W'(sc_vld), W'(1));
        chk("R8 b2b first data", sc_data, 32'd7);
        @(posedge clk); @(negedge clk);
        chk("R8 b2b second vld", W'(sc_vld), W'(1));
        chk("R8 b2b second data", sc_data, 32'hFFFFFFFC);
        chk("R8 b2b second exc", W'(sc_exc), W'(0));

        // pipelined contents untouched by scalar work (R9, R5)
        pipe_op(32'd0, 32'd0, 1'b0, 32'd11, 1'b0, "R9 drain");
        pipe_op(32'd0, 32'd0, 1'b0, 32'd22, 1'b0, "R9 drain");
        pipe_op(32'd0, 32'd0, 1'b0, 32'd33, 1'b1, "R5 drain exc");

        // reset mid-flight (R10)
        pipe_op(32'd1, 32'd1, 1'b1, 32'd0, 1'b0, "R2 fill");
        pipe_op(32'd2, 32'd2, 1'b0, 32'd0, 1'b0, "R2 fill");
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk("R10 mid reset res_data", res_data, '0);
        chk("R10 mid reset res_exc", W'(res_exc), W'(0));
        pipe_op(32'd0, 32'd0, 1'b0, 32'd0, 1'b0, "R10 drain");
        pipe_op(32'd0, 32'd0, 1'b0, 32'd0, 1'b0, "R10 drain");
        pipe_op(32'd0, 32'd0, 1'b0, 32'd0, 1'b0, "R10 drain");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule